// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable integer ratio and emits one single-cycle pulse per completed division cycle. Inside, a dual-modulus prescaler built from ordinary logic counts either 15 or 16 input clocks per output tick. A set/reset mode latch selects which of the two moduli is in use. A swallow counter counts prescaler ticks while the short modulus is active. When it reaches its target, it clears the latch, which moves the prescaler to the long modulus. A program counter counts every prescaler tick. When it reaches its target, it ends the division cycle and sets the latch again.

With program value P, swallow value S and prescaler base modulus 16, one cycle spans S short periods and P−S long ones, for a total of 16·P − S input clocks. A one-bit fractional control lengthens a single cycle by exactly one input clock. It does this by swallowing one period fewer. A modulator outside this block would toggle that bit cycle by cycle to obtain a fractional average ratio. P, S and the fractional bit are all captured together at the start of each division cycle, so changing them never disturbs a cycle that is already running.

Top module: `psw_divider`

## Requirements
- R1: While `rst_n` is low, `div_out` is 0. After `rst_n` is released, the first `div_out` pulse comes exactly 16·P − S + CS + 1 rising edges later. The extra edge is the one on which the configuration is captured.
- R2: With `frac_inc` = 0 and 1 ≤ S < P, consecutive `div_out` pulses are exactly 16·P − S input clocks apart. Examples are 369 (P=24, S=15), 357 (P=23, S=11), 246 (P=16, S=10) and 255 (P=16, S=1).
- R3: With `frac_inc` = 1 and 1 ≤ S < P, the spacing is 16·P − S + 1 input clocks.
- R4: With S = 0, the swallow phase is skipped, `frac_inc` has no effect, and the spacing is 16·P.
- R5: `prog_val`, `swal_val` and `frac_inc` are sampled only on the edge where `div_out` rises, and on the first edge after reset. A change in the middle of a cycle affects only the following cycle.
- R6: `div_out` is high for exactly one input clock per division cycle.
- R7: The prescaler divides by 15 while the mode latch is set and by 16 while it is clear. The ratio holds at both ends of the legal range, from P=2, S=1 (31) up to P=31, S=15 (481).
- R8: Asserting `rst_n` low in the middle of a cycle restarts the divider. After release, the first pulse again follows the timing of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_val | input | 5 | Program value P, legal range 1 to 31 |
| swal_val | input | 4 | Swallow value S, 0 up to P−1 |
| frac_inc | input | 1 | When 1, lengthens the next cycle by one input clock |
| div_out | output | 1 | One-clock pulse at the end of each division cycle |

## Verification
The pulse spacing is measured for several (P, S) pairs with the fractional bit clear. Because these pairs use different P and S values, a wrong weighting of either count shows up as a distinct error. The same pairs are then repeated with the bit set, which separates a correct one-clock extension from an off-by-one in the swallow target. S = 0 and the extremes of the legal range exercise the skipped swallow phase and the counter end points. A configuration change in the middle of a cycle and a reset in the middle of a cycle show whether inputs are captured only at the cycle boundary and whether the restart timing is correct.

// File: rtl/psw_div_pkg.sv
package psw_div_pkg;
  localparam int unsigned PRESC_HI = 16;
  localparam int unsigned PROG_W   = 5;
  localparam int unsigned SWAL_W   = 4;
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler #(
  parameter int unsigned N_HI = 16,
  localparam int unsigned PW  = $clog2(N_HI)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          short_mode,
  output logic          tick,
  output logic [PW-1:0] cnt
);
  localparam logic [PW-1:0] LAST_LONG  = PW'(N_HI - 1);
  localparam logic [PW-1:0] LAST_SHORT = PW'(N_HI - 2);

  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] last_val;

  always_comb begin
    last_val = short_mode ? LAST_SHORT : LAST_LONG;
    tick     = run && (cnt_q == last_val);
    cnt_d    = cnt_q;
    if (run) begin
      if (tick) cnt_d = '0;
      else      cnt_d = cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/psw_term_counter.sv
module psw_term_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] last_val,
  output logic [W-1:0] cnt,
  output logic         full
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    full  = en && (cnt_q == last_val);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (full) cnt_d = '0;
    else if (en)   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/psw_mode_latch.sv
module psw_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic clr,
  output logic q
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (load)     q_d = load_val;
    else if (clr) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b1;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_div_pkg::*;
#(
  parameter int unsigned N_HI = PRESC_HI,
  parameter int unsigned P_W  = PROG_W,
  parameter int unsigned S_W  = SWAL_W,
  localparam int unsigned PW  = $clog2(N_HI)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [P_W-1:0] prog_val,
  input  logic [S_W-1:0] swal_val,
  input  logic           frac_inc,
  output logic           div_out
);
  logic           armed_q, armed_d;
  logic [P_W-1:0] p_q, p_d;
  logic [S_W-1:0] s_eff_q, s_eff_d, s_eff_in;
  logic           div_q, div_d;
  logic           load, s_nz;
  logic           mode_q;
  logic           pre_tick;
  logic [PW-1:0]  pre_cnt;
  logic [S_W-1:0] sw_cnt, sw_last;
  logic [P_W-1:0] prog_cnt, prog_last;
  logic           sw_full, prog_full;

  always_comb begin
    s_eff_in  = (swal_val == '0) ? '0 : (swal_val - S_W'(frac_inc));
    s_nz      = (s_eff_in != '0);
    load      = !armed_q || prog_full;
    sw_last   = s_eff_q - S_W'(1);
    prog_last = p_q - P_W'(1);
    armed_d   = 1'b1;
    p_d       = load ? prog_val : p_q;
    s_eff_d   = load ? s_eff_in : s_eff_q;
    div_d     = prog_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      p_q     <= '0;
      s_eff_q <= '0;
      div_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      p_q     <= p_d;
      s_eff_q <= s_eff_d;
      div_q   <= div_d;
    end
  end

  psw_prescaler #(.N_HI(N_HI)) presc_i (
    .clk(clk), .rst_n(rst_n), .run(armed_q), .short_mode(mode_q),
    .tick(pre_tick), .cnt(pre_cnt)
  );

  psw_term_counter #(.W(S_W)) swal_i (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(pre_tick && mode_q),
    .last_val(sw_last), .cnt(sw_cnt), .full(sw_full)
  );

  psw_term_counter #(.W(P_W)) prog_i (
    .clk(clk), .rst_n(rst_n), .clr(load), .en(pre_tick),
    .last_val(prog_last), .cnt(prog_cnt), .full(prog_full)
  );

  psw_mode_latch latch_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(s_nz),
    .clr(sw_full), .q(mode_q)
  );

  assign div_out = div_q;
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk #(
  parameter int unsigned N_HI = 16,
  parameter int unsigned P_W  = 5,
  parameter int unsigned S_W  = 4,
  localparam int unsigned PW  = $clog2(N_HI)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           div_out,
  input logic           mode_q,
  input logic           armed_q,
  input logic [PW-1:0]  pre_cnt,
  input logic [S_W-1:0] sw_cnt,
  input logic [S_W-1:0] s_eff_q,
  input logic [P_W-1:0] prog_cnt
);
  localparam logic [PW-1:0] SHORT_LAST = PW'(N_HI - 2);

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  // R1
  quiet_before_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !div_out);

  // R7
  short_modulus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode_q) |-> (pre_cnt <= SHORT_LAST));

  // R4
  skip_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && s_eff_q == '0) |-> !mode_q);

  // R2
  swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && mode_q) |-> (sw_cnt < s_eff_q));

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(armed_q) && !div_out) |-> $stable(s_eff_q));

  // R6
  boundary_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> (prog_cnt == '0 && sw_cnt == '0));
endmodule

bind psw_divider psw_divider_chk #(.N_HI(N_HI), .P_W(P_W), .S_W(S_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .div_out(div_out), .mode_q(mode_q),
  .armed_q(armed_q), .pre_cnt(pre_cnt), .sw_cnt(sw_cnt),
  .s_eff_q(s_eff_q), .prog_cnt(prog_cnt)
);

// File: tb/psw_divider_tb.sv
module psw_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] prog_val;
  logic [3:0] swal_val;
  logic       frac_inc;
  logic       div_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  psw_divider dut_i (
    .clk(clk), .rst_n(rst_n), .prog_val(prog_val), .swal_val(swal_val),
    .frac_inc(frac_inc), .div_out(div_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WDOG_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check_int(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!div_out);
  endtask

  // counts negedges from the current pulse to the next, checking pulse width
  task automatic gap(input string req, output int n);
    @(negedge clk);
    check_int("R6 width", int'(div_out), 0);
    n = 1;
    while (!div_out) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic apply(input int p, input int s, input int cs);
    @(negedge clk);
    prog_val = 5'(p);
    swal_val = 4'(s);
    frac_inc = cs[0];
  endtask

  task automatic measure(input string req, input int p, input int s, input int cs, input int exp);
    int n;
    apply(p, s, cs);
    wait_pulse();
    wait_pulse();
    gap(req, n);
    check_int(req, n, exp);
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0;
    prog_val = 5'd16; swal_val = 4'd1; frac_inc = 1'b0;
    repeat (4) @(negedge clk);
    check_int("R1 reset quiet", int'(div_out), 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!div_out);
    check_int("R1 first pulse", n, 256);
  endtask

  task automatic t_midcycle_change();
    int n;
    apply(20, 5, 0);
    wait_pulse();
    wait_pulse();
    // R5: change in the middle of the running cycle
    repeat (50) @(negedge clk);
    prog_val = 5'd10; swal_val = 4'd3; frac_inc = 1'b1;
    n = 50;
    while (!div_out) begin @(negedge clk); n++; end
    check_int("R5 old cfg kept", n, 315);
    gap("R5", n);
    check_int("R5 new cfg used", n, 158);
  endtask

  task automatic t_reset_midcycle();
    int n;
    apply(24, 15, 0);
    wait_pulse();
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_int("R8 quiet in reset", int'(div_out), 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!div_out);
    check_int("R8 restart timing", n, 370);
  endtask

  initial begin
    t_reset();
    measure("R2 P24 S15", 24, 15, 0, 369);
    measure("R2 P23 S11", 23, 11, 0, 357);
    measure("R2 P16 S10", 16, 10, 0, 246);
    measure("R2 P16 S1",  16,  1, 0, 255);
    measure("R3 P24 S15", 24, 15, 1, 370);
    measure("R3 P23 S11", 23, 11, 1, 358);
    measure("R3 P16 S1",  16,  1, 1, 256);
    measure("R4 S0",      16,  0, 0, 256);
    measure("R4 S0 frac", 16,  0, 1, 256);
    measure("R7 P2 S1",    2,  1, 0, 31);
    measure("R7 P31 S15", 31, 15, 0, 481);
    measure("R7 P16 S15", 16, 15, 0, 241);
    t_midcycle_change();
    t_reset_midcycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule